// File: doc/BRIEF.md
# Segmented Real-Mode Address Generator

This block turns an operand reference into a physical memory address the way a 16-bit segmented processor does in its real addressing mode. It first forms a 16-bit offset by adding up to three terms: an optional base register, an optional index register and an optional displacement. The base is BX or BP, the index is SI or DI, and the displacement is either a sign-extended 8-bit value or a full 16-bit value. The offset wraps modulo 2^16. The block then shifts the 16-bit segment value left by four bits and adds the offset to it, which gives a 21-bit sum.

The `a20_en` input controls address line 20. When it is low, bit 20 is cleared, so an address past the 1 MB boundary wraps to the bottom of memory. When it is high, the full sum passes through, and segment 0xFFFF can reach up to 65520 bytes above 1 MB.

A request is a single-cycle strobe on `req_valid`, given with all operands valid. The address comes out of a register on the next cycle, marked by `out_valid`. The register keeps its value until the next request arrives.

Top module: `rm_agen`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `out_valid` and `out_addr` to zero at that edge.
- R2: `out_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low.
- R3: The offset is (base + index + displacement) modulo 2^16. Any carry out of bit 15 is lost before relocation.
- R4: `base_sel` picks the base term: 0 selects none (zero), 1 selects `reg_bx`, 2 selects `reg_bp`.
- R5: `idx_sel` picks the index term: 0 selects none (zero), 1 selects `reg_si`, 2 selects `reg_di`.
- R6: `disp_mode` picks the displacement term: 0 selects none (zero), 1 selects `disp[7:0]` sign-extended to 16 bits, 2 selects `disp[15:0]` as it is.
- R7: With `a20_en` high, `out_addr` equals `seg`*16 + offset as a 21-bit value. The largest result is 0x10FFEF.
- R8: With `a20_en` low, `out_addr[20]` is 0 and `out_addr[19:0]` equals the low 20 bits of `seg`*16 + offset.
- R9: In a cycle without a request, `out_addr` keeps the value it held before.
- R10: Code 3 on `base_sel`, `idx_sel` or `disp_mode` is reserved and gives a zero term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; operands are sampled with it |
| base_sel | input | 2 | Base register select (0 none, 1 BX, 2 BP, 3 reserved) |
| idx_sel | input | 2 | Index register select (0 none, 1 SI, 2 DI, 3 reserved) |
| disp_mode | input | 2 | Displacement mode (0 none, 1 sign-extended 8-bit, 2 16-bit, 3 reserved) |
| disp | input | 16 | Displacement value |
| reg_bx | input | 16 | BX register value |
| reg_bp | input | 16 | BP register value |
| reg_si | input | 16 | SI register value |
| reg_di | input | 16 | DI register value |
| seg | input | 16 | Segment value |
| a20_en | input | 1 | High: address bit 20 passes through; low: it is forced to 0 |
| out_valid | output | 1 | Address valid, one cycle after the request |
| out_addr | output | 21 | Registered physical address |

## Verification
The hardest case to reach is the one where both wraps happen at once. The offset terms must carry out of bit 15, and the relocated sum must also cross 1 MB, so both truncations act on the same request. The bench sweeps every select and mode code against operand sets chosen near the top of their ranges: 0xFFFF-class registers, an 8-bit displacement of 0x80, and segments 0xFFFF and 0xF000. Each of these requests runs with the gate both open and closed, so the carry out of bit 15 and the crossing of 1 MB are each seen with and without the other. Idle cycles between requests show that the address holds and the valid strobe drops.

// File: rtl/rm_agen_pkg.sv
package rm_agen_pkg;

    localparam int SEG_W   = 16;
    localparam int OFF_W   = 16;
    localparam int SHIFT   = 4;
    localparam int ADDR_W  = SEG_W + SHIFT + 1;
    localparam int WRAP_BIT = ADDR_W - 1;
    localparam int DISP8_W = 8;

    typedef enum logic [1:0] {
        BASE_NONE = 2'd0,
        BASE_BX   = 2'd1,
        BASE_BP   = 2'd2,
        BASE_RSVD = 2'd3
    } base_sel_e;

    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_SI   = 2'd1,
        IDX_DI   = 2'd2,
        IDX_RSVD = 2'd3
    } idx_sel_e;

    typedef enum logic [1:0] {
        DISP_NONE = 2'd0,
        DISP_8    = 2'd1,
        DISP_16   = 2'd2,
        DISP_RSVD = 2'd3
    } disp_mode_e;

    typedef struct packed {
        logic [OFF_W-1:0] bx;
        logic [OFF_W-1:0] bp;
        logic [OFF_W-1:0] si;
        logic [OFF_W-1:0] di;
    } ptr_regs_t;

    typedef struct packed {
        base_sel_e        base;
        idx_sel_e         idx;
        disp_mode_e       dmode;
        logic [OFF_W-1:0] disp;
    } ea_req_t;

    function automatic logic [OFF_W-1:0] sext_disp8(input logic [DISP8_W-1:0] d);
        return {{(OFF_W-DISP8_W){d[DISP8_W-1]}}, d};
    endfunction

endpackage

// File: rtl/rm_offset_calc.sv
module rm_offset_calc
    import rm_agen_pkg::*;
(
    input  ea_req_t          req,
    input  ptr_regs_t        regs,
    output logic [OFF_W-1:0] offset
);
    logic [OFF_W-1:0] base_term;
    logic [OFF_W-1:0] idx_term;
    logic [OFF_W-1:0] disp_term;

    always_comb begin
        unique case (req.base)
            BASE_BX: base_term = regs.bx;
            BASE_BP: base_term = regs.bp;
            default: base_term = '0;
        endcase
    end

    always_comb begin
        unique case (req.idx)
            IDX_SI:  idx_term = regs.si;
            IDX_DI:  idx_term = regs.di;
            default: idx_term = '0;
        endcase
    end

    always_comb begin
        unique case (req.dmode)
            DISP_8:  disp_term = sext_disp8(req.disp[DISP8_W-1:0]);
            DISP_16: disp_term = req.disp;
            default: disp_term = '0;
        endcase
    end

    // Offset wraps at 2^OFF_W: the carry out of the top bit is dropped.
    always_comb offset = base_term + idx_term + disp_term;

endmodule

// File: rtl/rm_reloc.sv
module rm_reloc
    import rm_agen_pkg::*;
(
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  offset,
    input  logic              a20_en,
    output logic [ADDR_W-1:0] phys
);
    logic [ADDR_W-1:0] seg_base;
    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        seg_base = {{(ADDR_W-SEG_W-SHIFT){1'b0}}, seg, {SHIFT{1'b0}}};
        off_ext  = {{(ADDR_W-OFF_W){1'b0}}, offset};
        sum      = seg_base + off_ext;
        phys     = sum;
        if (!a20_en) phys[WRAP_BIT] = 1'b0;
    end

endmodule

// File: rtl/rm_agen.sv
module rm_agen
    import rm_agen_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [1:0]              base_sel,
    input  logic [1:0]              idx_sel,
    input  logic [1:0]              disp_mode,
    input  logic [15:0]             disp,
    input  logic [15:0]             reg_bx,
    input  logic [15:0]             reg_bp,
    input  logic [15:0]             reg_si,
    input  logic [15:0]             reg_di,
    input  logic [15:0]             seg,
    input  logic                    a20_en,
    output logic                    out_valid,
    output logic [20:0]             out_addr
);
    ea_req_t           req;
    ptr_regs_t         regs;
    logic [OFF_W-1:0]  offset;
    logic [ADDR_W-1:0] phys;

    always_comb begin
        req.base  = base_sel_e'(base_sel);
        req.idx   = idx_sel_e'(idx_sel);
        req.dmode = disp_mode_e'(disp_mode);
        req.disp  = disp;
        regs.bx   = reg_bx;
        regs.bp   = reg_bp;
        regs.si   = reg_si;
        regs.di   = reg_di;
    end

    rm_offset_calc u_off (
        .req    (req),
        .regs   (regs),
        .offset (offset)
    );

    rm_reloc u_reloc (
        .seg    (seg),
        .offset (offset),
        .a20_en (a20_en),
        .phys   (phys)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) out_addr <= phys;
        end
    end

endmodule

// File: rtl/rm_agen_chk.sv
module rm_agen_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [1:0]  base_sel,
    input logic [1:0]  idx_sel,
    input logic [1:0]  disp_mode,
    input logic [15:0] disp,
    input logic [15:0] seg,
    input logic        a20_en,
    input logic        out_valid,
    input logic [20:0] out_addr
);
    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_addr == 21'd0));

    // R2
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    p_valid_drops_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    // R7
    p_addr_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_addr <= 21'h10FFEF));
    p_seg_disp16_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && a20_en && base_sel == 2'd0 && idx_sel == 2'd0 && disp_mode == 2'd2)
        |=> (out_addr == ({5'd0, $past(seg)} << 4) + {5'd0, $past(disp)}));

    // R8
    p_gate_low_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !a20_en) |=> !out_addr[20]);

    // R9
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(out_addr));

endmodule

bind rm_agen rm_agen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .base_sel  (base_sel),
    .idx_sel   (idx_sel),
    .disp_mode (disp_mode),
    .disp      (disp),
    .seg       (seg),
    .a20_en    (a20_en),
    .out_valid (out_valid),
    .out_addr  (out_addr)
);

// File: tb/sim_rm_agen.sv
module sim_rm_agen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  base_sel = '0;
    logic [1:0]  idx_sel = '0;
    logic [1:0]  disp_mode = '0;
    logic [15:0] disp = '0;
    logic [15:0] reg_bx = '0;
    logic [15:0] reg_bp = '0;
    logic [15:0] reg_si = '0;
    logic [15:0] reg_di = '0;
    logic [15:0] seg = '0;
    logic        a20_en = 1'b0;
    logic        out_valid;
    logic [20:0] out_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rm_agen u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .base_sel(base_sel), .idx_sel(idx_sel), .disp_mode(disp_mode),
        .disp(disp), .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si),
        .reg_di(reg_di), .seg(seg), .a20_en(a20_en),
        .out_valid(out_valid), .out_addr(out_addr)
    );

    function automatic logic [20:0] model(
        input logic [1:0] b, input logic [1:0] i, input logic [1:0] dm,
        input logic [15:0] d, input logic [15:0] bx, input logic [15:0] bp,
        input logic [15:0] si, input logic [15:0] di, input logic [15:0] s,
        input logic g);
        int bv, iv, dv, off, p;
        bv = (b == 2'd1) ? int'(bx) : (b == 2'd2) ? int'(bp) : 0;   // R4, R10
        iv = (i == 2'd1) ? int'(si) : (i == 2'd2) ? int'(di) : 0;   // R5, R10
        dv = 0;                                                     // R6, R10
        if (dm == 2'd1) dv = (d[7] ? int'(d[7:0]) - 256 : int'(d[7:0]));
        else if (dm == 2'd2) dv = int'(d);
        off = (bv + iv + dv) & 32'hFFFF;                            // R3
        p = int'(s) * 16 + off;                                     // R7
        if (!g) p = p & 32'hFFFFF;                                  // R8
        return p[20:0];
    endfunction

    task automatic check(input logic [20:0] act, input logic [20:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request; sample one cycle later, then one idle cycle.
    task automatic run_req(input logic [1:0] b, input logic [1:0] i, input logic [1:0] dm,
                           input logic [15:0] d, input logic [15:0] s, input logic g,
                           input string tag, input bit idle_chk);
        logic [20:0] exp;
        @(negedge clk);
        req_valid = 1'b1; base_sel = b; idx_sel = i; disp_mode = dm;
        disp = d; seg = s; a20_en = g;
        exp = model(b, i, dm, d, reg_bx, reg_bp, reg_si, reg_di, s, g);
        @(negedge clk);
        req_valid = 1'b0;
        check({20'd0, out_valid}, 21'd1, "R2 valid after request");
        check(out_addr, exp, tag);
        if (idle_chk) begin
            base_sel = ~b; seg = ~s; disp = ~d; a20_en = ~g;
            @(negedge clk);
            check({20'd0, out_valid}, 21'd0, "R2 valid drops when idle");
            check(out_addr, exp, "R9 address held while idle");
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, including after a request in flight
        repeat (2) @(negedge clk);
        check({20'd0, out_valid}, 21'd0, "R1 reset valid");
        check(out_addr, 21'd0, "R1 reset addr");
        rst = 1'b0;
        reg_bx = 16'h1234; reg_bp = 16'h0400; reg_si = 16'h0010; reg_di = 16'h0002;
        run_req(2'd1, 2'd1, 2'd2, 16'h0100, 16'h2000, 1'b1, "R7 basic", 1'b0);
        @(negedge clk);
        req_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; rst = 1'b0;
        check({20'd0, out_valid}, 21'd0, "R1 reset beats request valid");
        check(out_addr, 21'd0, "R1 reset beats request addr");

        // Boundary: gate open reaches 65520 bytes above 1 MB (R7), closed wraps (R8)
        reg_bx = 16'hFFFF;
        run_req(2'd0, 2'd0, 2'd2, 16'hFFFF, 16'hFFFF, 1'b1, "R7 top of HMA", 1'b1);
        check(out_addr, 21'h10FFEF, "R7 literal 0x10FFEF");
        run_req(2'd0, 2'd0, 2'd2, 16'hFFFF, 16'hFFFF, 1'b0, "R8 wrap below 1MB", 1'b1);
        check(out_addr, 21'h0FFEF, "R8 literal 0x0FFEF");
        // R3: offset wrap BX=FFFF + SI=2 -> 1
        reg_si = 16'h0002;
        run_req(2'd1, 2'd1, 2'd0, 16'h0000, 16'h0000, 1'b1, "R3 offset wrap", 1'b1);
        check(out_addr, 21'h00001, "R3 literal 0x00001");
        // R6: 8-bit displacement 0x80 is -128
        reg_bp = 16'h0100;
        run_req(2'd2, 2'd0, 2'd1, 16'h7F80, 16'h0000, 1'b1, "R6 sign extension", 1'b1);
        check(out_addr, 21'h00080, "R6 literal 0x00080");
        // R10: all-reserved codes give segment base only
        run_req(2'd3, 2'd3, 2'd3, 16'h5555, 16'h0123, 1'b1, "R10 reserved codes", 1'b1);
        check(out_addr, 21'h01230, "R10 literal 0x01230");

        // Sweep every code combination over several operand sets (R4, R5, R6, R10, R3, R7, R8)
        for (int set = 0; set < 4; set++) begin
            case (set)
                0: begin reg_bx = 16'h0100; reg_bp = 16'h0200; reg_si = 16'h0030; reg_di = 16'h0004; end
                1: begin reg_bx = 16'hFFF0; reg_bp = 16'h8000; reg_si = 16'h0020; reg_di = 16'h8001; end
                2: begin reg_bx = 16'hFFFF; reg_bp = 16'hFFFE; reg_si = 16'hFFFF; reg_di = 16'h0001; end
                default: begin reg_bx = 16'h1357; reg_bp = 16'h2468; reg_si = 16'hA5A5; reg_di = 16'h5A5A; end
            endcase
            for (int sg = 0; sg < 3; sg++) begin
                for (int b = 0; b < 4; b++) begin
                    for (int i = 0; i < 4; i++) begin
                        for (int dm = 0; dm < 4; dm++) begin
                            for (int g = 0; g < 2; g++) begin
                                logic [15:0] sv;
                                logic [15:0] dv;
                                sv = (sg == 0) ? 16'h0000 : (sg == 1) ? 16'hF000 : 16'hFFFF;
                                dv = (set[0]) ? 16'h8080 : 16'h017F;
                                run_req(b[1:0], i[1:0], dm[1:0], dv, sv, g[0],
                                        "R4 R5 R6 R7 R8 R10 sweep", (b == 3 && i == 3));
                            end
                        end
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule